// File: doc/BRIEF.md
# Element Loop Sequencer

This block turns one already-decoded scalar instruction into a run of internal micro-operations, one for each vector element. It takes the instruction's destination and two source register numbers, plus a vector-enable bit and a vector length. It then issues one micro-operation per cycle. Each micro-operation adds the element index to all three register numbers. While a run is in progress the block is busy and accepts no new instruction. The opcode field is carried through unchanged and is never interpreted.

Each element lane has its own carry bit, so a carry-consuming operation in lane i reads only lane i's bit. The eight lane carries form one special register that software can read and write, so the whole set can be saved and restored across a context switch. When only one element is issued, the separate scalar carry bit is used instead. Vector runs send their condition results to condition field 6, and scalar issues use field 0. A run whose register numbers would pass register 31, or whose length is above the maximum, is refused: the block raises an illegal-configuration pulse and issues nothing.

Top module: `elem_loop_seq`

## Requirements
- R1: After reset, busy, uop_valid and illegal are 0, and the lane carry register reads 0.
- R2: An instruction accepted with vec_en=0, or with vl of 0 or 1, issues exactly one micro-operation in the cycle after acceptance. That micro-operation has the original register numbers, uop_elem=0 and uop_last=1, and its carry-in is the scalar carry bit.
- R3: An instruction accepted with vec_en=1 and vl in 2..8 issues vl micro-operations on consecutive cycles, starting the cycle after acceptance. Element i carries uop_elem=i and register numbers base+i, and uop_last is 1 only on element vl-1.
- R4: busy is 1 from the cycle after acceptance until the last micro-operation, inclusive. An in_valid presented while busy is 1 is ignored and does not alter the run in progress.
- R5: The carry-in of vector element i equals bit i of the lane carry register.
- R6: A cout_valid with cout_vec=1 writes cout_bit into lane bit cout_elem only, visible on spr_rdata the next cycle. A cout_valid with cout_vec=0 updates only the scalar carry and leaves spr_rdata unchanged.
- R7: spr_we loads spr_wdata into the lane carry register, readable on spr_rdata the next cycle. If cout_valid with cout_vec=1 arrives in the same cycle, spr_we takes precedence.
- R8: uop_cr_field is 6 for every micro-operation of a vector run and 0 for a scalar issue.
- R9: An accepted instruction with vec_en=1 that has vl above 8, or whose base register plus vl-1 exceeds 31 for rd, ra or rb, issues nothing. It pulses illegal for exactly one cycle, the cycle after acceptance, and busy stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction offered; taken when busy is 0 |
| in_op | input | OPW | Opaque opcode bits, passed through |
| in_rd | input | RW | Base destination register |
| in_ra | input | RW | Base first source register |
| in_rb | input | RW | Base second source register |
| in_vec_en | input | 1 | Vector mode enable |
| in_vl | input | LW | Vector length (legal 0..8) |
| cout_valid | input | 1 | Carry result returned by execution |
| cout_vec | input | 1 | Returned carry belongs to a vector lane |
| cout_elem | input | EW | Lane of the returned carry |
| cout_bit | input | 1 | Returned carry value |
| spr_we | input | 1 | Write the lane carry register |
| spr_wdata | input | MAXVL | Lane carry write data |
| busy | output | 1 | Run in progress; no acceptance |
| uop_valid | output | 1 | Micro-operation issued this cycle |
| uop_op | output | OPW | Opcode of the micro-operation |
| uop_rd | output | RW | Destination register for this element |
| uop_ra | output | RW | First source register for this element |
| uop_rb | output | RW | Second source register for this element |
| uop_elem | output | EW | Element index |
| uop_last | output | 1 | Final element of the run |
| uop_carry_in | output | 1 | Carry-in for this element |
| uop_cr_field | output | 3 | Condition field targeted |
| illegal | output | 1 | Refused configuration pulse |
| spr_rdata | output | MAXVL | Lane carry register contents |

## Verification
The assertions assume that execution units return carries only for lane indices below the maximum length. They also assume that spr_we and the carry inputs are held low during reset, because the write and lane-update properties compare against the previous cycle's inputs. The directed stimulus changes inputs only on the falling edge and keeps every cout_elem inside 0..7. It offers new instructions during a run only to show that they are ignored, and it releases them before the run ends.

// File: rtl/elem_loop_seq.sv
module elem_loop_seq #(
  parameter int RW     = 5,
  parameter int MAXVL  = 8,
  parameter int OPW    = 8,
  parameter int CR_VEC = 6,
  parameter int CR_SCL = 0
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          in_valid,
  input  logic [OPW-1:0]                in_op,
  input  logic [RW-1:0]                 in_rd,
  input  logic [RW-1:0]                 in_ra,
  input  logic [RW-1:0]                 in_rb,
  input  logic                          in_vec_en,
  input  logic [$clog2(MAXVL+1)-1:0]    in_vl,
  input  logic                          cout_valid,
  input  logic                          cout_vec,
  input  logic [$clog2(MAXVL)-1:0]      cout_elem,
  input  logic                          cout_bit,
  input  logic                          spr_we,
  input  logic [MAXVL-1:0]              spr_wdata,
  output logic                          busy,
  output logic                          uop_valid,
  output logic [OPW-1:0]                uop_op,
  output logic [RW-1:0]                 uop_rd,
  output logic [RW-1:0]                 uop_ra,
  output logic [RW-1:0]                 uop_rb,
  output logic [$clog2(MAXVL)-1:0]      uop_elem,
  output logic                          uop_last,
  output logic                          uop_carry_in,
  output logic [2:0]                    uop_cr_field,
  output logic                          illegal,
  output logic [MAXVL-1:0]              spr_rdata
);
  localparam int EW   = $clog2(MAXVL);
  localparam int LW   = $clog2(MAXVL+1);
  localparam int NREG = 1 << RW;

  logic           busy_q, vec_q, illegal_q, ca_q;
  logic [OPW-1:0] op_q;
  logic [RW-1:0]  rd_q, ra_q, rb_q;
  logic [EW-1:0]  cnt_q, end_q;
  logic [MAXVL-1:0] lanes_q;

  logic          take, vec_req, too_long, wraps, bad;
  logic [LW-1:0] span;

  assign take     = in_valid && !busy_q;
  assign vec_req  = in_vec_en && (in_vl > LW'(1));
  assign span     = vec_req ? in_vl - LW'(1) : '0;
  assign too_long = in_vec_en && (in_vl > LW'(MAXVL));

  always_comb begin
    wraps = 1'b0;
    if (({1'b0, in_rd} + (RW+1)'(span)) > (RW+1)'(NREG-1)) wraps = 1'b1;
    if (({1'b0, in_ra} + (RW+1)'(span)) > (RW+1)'(NREG-1)) wraps = 1'b1;
    if (({1'b0, in_rb} + (RW+1)'(span)) > (RW+1)'(NREG-1)) wraps = 1'b1;
  end

  assign bad = too_long || wraps;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy_q    <= 1'b0;
      vec_q     <= 1'b0;
      illegal_q <= 1'b0;
      op_q      <= '0;
      rd_q      <= '0;
      ra_q      <= '0;
      rb_q      <= '0;
      cnt_q     <= '0;
      end_q     <= '0;
    end else begin
      illegal_q <= take && bad;
      if (take && !bad) begin
        busy_q <= 1'b1;
        vec_q  <= vec_req;
        op_q   <= in_op;
        rd_q   <= in_rd;
        ra_q   <= in_ra;
        rb_q   <= in_rb;
        cnt_q  <= '0;
        end_q  <= span[EW-1:0];
      end else if (busy_q) begin
        if (cnt_q == end_q) busy_q <= 1'b0;
        else                cnt_q  <= cnt_q + EW'(1);
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lanes_q <= '0;
      ca_q    <= 1'b0;
    end else begin
      if (spr_we)
        lanes_q <= spr_wdata;
      else if (cout_valid && cout_vec)
        lanes_q[cout_elem] <= cout_bit;
      if (cout_valid && !cout_vec)
        ca_q <= cout_bit;
    end
  end

  assign busy         = busy_q;
  assign uop_valid    = busy_q;
  assign uop_op       = op_q;
  assign uop_rd       = rd_q + RW'(cnt_q);
  assign uop_ra       = ra_q + RW'(cnt_q);
  assign uop_rb       = rb_q + RW'(cnt_q);
  assign uop_elem     = cnt_q;
  assign uop_last     = busy_q && (cnt_q == end_q);
  assign uop_carry_in = vec_q ? lanes_q[cnt_q] : ca_q;
  assign uop_cr_field = vec_q ? 3'(CR_VEC) : 3'(CR_SCL);
  assign illegal      = illegal_q;
  assign spr_rdata    = lanes_q;
endmodule

// File: rtl/elem_loop_seq_chk.sv
module elem_loop_seq_chk #(
  parameter int RW     = 5,
  parameter int MAXVL  = 8,
  parameter int CR_VEC = 6
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     busy,
  input logic                     uop_valid,
  input logic [RW-1:0]            uop_rd,
  input logic [RW-1:0]            uop_ra,
  input logic [RW-1:0]            uop_rb,
  input logic [$clog2(MAXVL)-1:0] uop_elem,
  input logic                     uop_last,
  input logic                     uop_carry_in,
  input logic [2:0]               uop_cr_field,
  input logic                     illegal,
  input logic [MAXVL-1:0]         spr_rdata,
  input logic                     spr_we,
  input logic [MAXVL-1:0]         spr_wdata,
  input logic                     cout_valid,
  input logic                     cout_vec,
  input logic [$clog2(MAXVL)-1:0] cout_elem,
  input logic                     cout_bit
);
  AST_STEP_REGS: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_last |=> uop_valid && uop_rd == $past(uop_rd) + 1'b1 &&
      uop_ra == $past(uop_ra) + 1'b1 && uop_rb == $past(uop_rb) + 1'b1 &&
      uop_elem == $past(uop_elem) + 1'b1); // R3
  AST_BUSY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && !uop_last |=> busy); // R4
  AST_SCALAR_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_cr_field != 3'(CR_VEC) |-> uop_last && uop_elem == '0); // R2
  AST_VEC_FIELD: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_elem != '0 |-> uop_cr_field == 3'(CR_VEC)); // R8
  AST_LANE_CARRY_IN: assert property (@(posedge clk) disable iff (!rst_n)
    uop_valid && uop_cr_field == 3'(CR_VEC) |-> uop_carry_in == spr_rdata[uop_elem]); // R5
  AST_LANE_UPDATE: assert property (@(posedge clk) disable iff (!rst_n)
    cout_valid && cout_vec && !spr_we |=> spr_rdata[$past(cout_elem)] == $past(cout_bit)); // R6
  AST_SPR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    spr_we |=> spr_rdata == $past(spr_wdata)); // R7
  AST_ILLEGAL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> !uop_valid && !busy); // R9
endmodule

bind elem_loop_seq elem_loop_seq_chk #(.RW(RW), .MAXVL(MAXVL), .CR_VEC(CR_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .uop_valid(uop_valid),
  .uop_rd(uop_rd), .uop_ra(uop_ra), .uop_rb(uop_rb), .uop_elem(uop_elem),
  .uop_last(uop_last), .uop_carry_in(uop_carry_in), .uop_cr_field(uop_cr_field),
  .illegal(illegal), .spr_rdata(spr_rdata), .spr_we(spr_we), .spr_wdata(spr_wdata),
  .cout_valid(cout_valid), .cout_vec(cout_vec), .cout_elem(cout_elem),
  .cout_bit(cout_bit)
);

// File: tb/sim_elem_loop_seq.sv
`timescale 1ns/1ps
module sim_elem_loop_seq;
  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 0, in_vec_en = 0, cout_valid = 0, cout_vec = 0, cout_bit = 0, spr_we = 0;
  logic [7:0] in_op = 0, spr_wdata = 0;
  logic [4:0] in_rd = 0, in_ra = 0, in_rb = 0;
  logic [3:0] in_vl = 0;
  logic [2:0] cout_elem = 0;
  logic busy, uop_valid, uop_last, uop_carry_in, illegal;
  logic [7:0] uop_op, spr_rdata;
  logic [4:0] uop_rd, uop_ra, uop_rb;
  logic [2:0] uop_elem, uop_cr_field;
  int checks = 0, failures = 0;
  bit done = 0;

  always #4 clk = ~clk;

  elem_loop_seq u0 (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic offer(input logic [4:0] rd, ra, rb, input logic ven, input logic [3:0] vl);
    @(negedge clk);
    in_op = 8'h5C; in_rd = rd; in_ra = ra; in_rb = rb; in_vec_en = ven; in_vl = vl;
    in_valid = 1;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic walk(input logic [4:0] rd, ra, rb, input int n, input logic [7:0] lanes,
                      input bit vec, input logic sca);
    for (int i = 0; i < n; i++) begin
      chk(uop_valid && busy, "R4", uop_valid, 1);
      chk(uop_rd == rd + i && uop_ra == ra + i && uop_rb == rb + i, "R3", uop_rd, rd + i);
      chk(uop_elem == i && uop_last == (i == n - 1), "R3", uop_elem, i);
      chk(uop_op == 8'h5C, "R2", uop_op, 8'h5C);
      chk(uop_cr_field == (vec ? 3'd6 : 3'd0), "R8", uop_cr_field, vec ? 6 : 0);
      if (vec) chk(uop_carry_in == lanes[i], "R5", uop_carry_in, lanes[i]);
      else     chk(uop_carry_in == sca, "R2", uop_carry_in, sca);
      if (i == n - 1) in_valid = 0;
      @(negedge clk);
    end
    chk(!uop_valid && !busy, "R4", busy, 0);
  endtask

  task automatic t_reset;
    chk(!busy && !uop_valid && !illegal, "R1", busy, 0);
    chk(spr_rdata == 8'h00, "R1", spr_rdata, 0);
  endtask

  task automatic t_spr;
    @(negedge clk); spr_we = 1; spr_wdata = 8'hA5;
    @(negedge clk); spr_we = 0;
    chk(spr_rdata == 8'hA5, "R7", spr_rdata, 8'hA5);
    spr_we = 1; spr_wdata = 8'h3C; cout_valid = 1; cout_vec = 1; cout_elem = 0; cout_bit = 1;
    @(negedge clk); spr_we = 0; cout_valid = 0;
    chk(spr_rdata == 8'h3C, "R7", spr_rdata, 8'h3C);
    spr_we = 1; spr_wdata = 8'hA5;
    @(negedge clk); spr_we = 0;
  endtask

  task automatic t_scalar;
    @(negedge clk); cout_valid = 1; cout_vec = 0; cout_bit = 1;
    @(negedge clk); cout_valid = 0;
    chk(spr_rdata == 8'hA5, "R6", spr_rdata, 8'hA5);
    offer(5'd7, 5'd9, 5'd31, 1'b0, 4'd5);
    walk(5'd7, 5'd9, 5'd31, 1, 8'hA5, 0, 1'b1);
    offer(5'd31, 5'd2, 5'd3, 1'b1, 4'd1);
    walk(5'd31, 5'd2, 5'd3, 1, 8'hA5, 0, 1'b1);
    offer(5'd4, 5'd5, 5'd6, 1'b1, 4'd0);
    walk(5'd4, 5'd5, 5'd6, 1, 8'hA5, 0, 1'b1);
  endtask

  task automatic t_vector;
    offer(5'd8, 5'd16, 5'd0, 1'b1, 4'd8);
    walk(5'd8, 5'd16, 5'd0, 8, 8'hA5, 1, 1'b0);
    offer(5'd28, 5'd1, 5'd20, 1'b1, 4'd4);
    walk(5'd28, 5'd1, 5'd20, 4, 8'hA5, 1, 1'b0);
    offer(5'd10, 5'd11, 5'd12, 1'b1, 4'd2);
    walk(5'd10, 5'd11, 5'd12, 2, 8'hA5, 1, 1'b0);
  endtask

  task automatic t_stall;
    offer(5'd4, 5'd4, 5'd4, 1'b1, 4'd4);
    in_rd = 5'd20; in_ra = 5'd21; in_rb = 5'd22; in_vl = 4'd2; in_valid = 1;
    walk(5'd4, 5'd4, 5'd4, 4, 8'hA5, 1, 1'b0);
    chk(!uop_valid, "R4", uop_valid, 0);
  endtask

  task automatic t_lane_cout;
    @(negedge clk); cout_valid = 1; cout_vec = 1; cout_elem = 3'd5; cout_bit = 0;
    @(negedge clk); cout_valid = 0;
    chk(spr_rdata == 8'h85, "R6", spr_rdata, 8'h85);
    cout_valid = 1; cout_elem = 3'd6; cout_bit = 1;
    @(negedge clk); cout_valid = 0;
    chk(spr_rdata == 8'hC5, "R6", spr_rdata, 8'hC5);
    offer(5'd0, 5'd0, 5'd0, 1'b1, 4'd8);
    walk(5'd0, 5'd0, 5'd0, 8, 8'hC5, 1, 1'b0);
  endtask

  task automatic t_illegal(input logic [4:0] rd, ra, rb, input logic [3:0] vl);
    offer(rd, ra, rb, 1'b1, vl);
    chk(illegal && !uop_valid && !busy, "R9", illegal, 1);
    @(negedge clk);
    chk(!illegal && !uop_valid && !busy, "R9", illegal, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1;
    t_spr();
    t_scalar();
    t_vector();
    t_stall();
    t_lane_cout();
    t_illegal(5'd30, 5'd0, 5'd0, 4'd4);
    t_illegal(5'd0, 5'd29, 5'd0, 4'd4);
    t_illegal(5'd0, 5'd0, 5'd25, 4'd8);
    t_illegal(5'd0, 5'd0, 5'd0, 4'd9);
    offer(5'd1, 5'd2, 5'd3, 1'b1, 4'd3);
    walk(5'd1, 5'd2, 5'd3, 3, 8'hC5, 1, 1'b0);
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule